// File: doc/BRIEF.md
# Dual-Buffer Instruction Prefetcher

This block sits between an instruction fetch front end and an instruction cache. It owns two line-sized fetch buffers, each holding an address tag, a request number and an outstanding flag. For each fetch PC the block aligns the address down to the fetch size and picks a current buffer: a buffer whose tag equals the aligned address, or buffer 1 by default. It loads that buffer on a miss and makes the other buffer hold the next sequential line, loading it if needed. Requests leave one at a time on a single request port. Each request carries a number from a running counter. Cache responses return that number and free the buffer it belongs to.

While the current buffer is outstanding, the fetch stalls and the stall cycles are counted. A branch penalty can be armed at any time. It is paid as stall cycles once, on the next fetch that starts a packet, and is then cleared. When both the instruction cache and cycle accounting are off, the block issues no requests. When only cycle accounting is off, requests are issued but the fetch neither stalls nor pays a penalty.

The controller is a six-state machine. `ST_IDLE` accepts a fetch. `ST_REQ_CUR` checks and loads the current buffer. `ST_REQ_NXT` checks and loads the next-line buffer. `ST_PENALTY` burns the branch penalty. `ST_WAIT` holds until the current buffer is no longer outstanding. `ST_DONE` gives a one-cycle completion pulse. The transitions are:
- IDLE→REQ_CUR: a fetch arrives while the block is active.
- IDLE→DONE: a fetch arrives while the block is suppressed.
- REQ_CUR→REQ_NXT: always.
- REQ_NXT→DONE: accounting is off.
- REQ_NXT→PENALTY: a packet-first fetch with a nonzero penalty armed.
- REQ_NXT→WAIT: otherwise.
- PENALTY→WAIT: the penalty count is exhausted.
- WAIT→DONE: the current buffer is not outstanding.
- DONE→IDLE: always.

Top module: `ifp_prefetch`

## Requirements
- R1: After reset, `req_valid`, `fetch_done` and `stall` are 0 and `wait_cycles` is 0. The first request issued carries request number 0x80000000.
- R2: Every request address has its low log2(FETCH_BYTES) bits cleared. The current-buffer request uses `fetch_pc` with those bits cleared.
- R3: If a buffer's tag equals the aligned PC, that buffer becomes current (`cur_buf`), buffer 0 being checked first. No request is made for it.
- R4: If neither buffer matches, buffer 1 becomes current, is retagged with the aligned PC, and a request is issued for it before any next-line request.
- R5: The non-current buffer must hold aligned PC + FETCH_BYTES. If it does not, it is retagged and requested, and this request follows the current-buffer request in the next cycle.
- R6: Each issued request carries the previous request number plus one.
- R7: A response (`rsp_valid`, `rsp_id`) clears the outstanding flag only of the buffer whose pending request number equals `rsp_id`. A response for the other buffer does not end the stall.
- R8: With accounting on, `stall` stays high while the current buffer is outstanding. `fetch_done` pulses for one cycle. It pulses in the (4+P+W)-th cycle after the accepting clock edge, where P is the penalty paid and W is the number of wait cycles with the current buffer outstanding. `wait_cycles` reports W for the latest fetch.
- R9: An armed penalty (`pen_set`, `pen_val`) is paid only by a fetch with `fetch_first`=1 and accounting on, and is then cleared. A fetch with `fetch_first`=0 leaves it armed.
- R10: With `cache_en`=0 and `count_en`=0, a fetch issues no request and `fetch_done` pulses in the first cycle after acceptance.
- R11: With `cache_en`=1 and `count_en`=0, the requests of R4/R5 are issued and `fetch_done` pulses in the third cycle, with no penalty or wait stall. An armed penalty stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request, taken when idle |
| fetch_pc | input | AW | Fetch byte address |
| fetch_first | input | 1 | Fetch starts a new packet |
| cache_en | input | 1 | Instruction cache enabled |
| count_en | input | 1 | Cycle accounting enabled |
| pen_set | input | 1 | Arm a branch penalty |
| pen_val | input | PW | Penalty length in cycles |
| rsp_valid | input | 1 | Cache load completion |
| rsp_id | input | IDW | Request number being completed |
| req_valid | output | 1 | Line load request |
| req_buf | output | 1 | Buffer index of the request |
| req_addr | output | AW | Aligned line address |
| req_id | output | IDW | Request number |
| stall | output | 1 | Front end must hold |
| fetch_done | output | 1 | One-cycle fetch completion |
| cur_buf | output | 1 | Current buffer of the latest fetch |
| wait_cycles | output | WW | Wait cycles of the latest fetch |

## Verification
A fetch sequence is run with the cache answering one cycle after each request. The sequence covers a cold miss, a hit in the default buffer, and a hit in buffer 0. It also covers a sequential step that only refills the next line, a far jump, and a miss whose next line is already present. Together these separate the hit, default-choice and next-line paths, and the bench checks the request order and numbering each time. Directed cases answer the prefetch before the current line, to show that only a matching number releases the stall and that the wait count is exact. Further cases check that the penalty is paid once and only at packet starts, and exercise the two suppressed accounting settings.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_CUR,
        ST_REQ_NXT,
        ST_PENALTY,
        ST_WAIT,
        ST_DONE
    } ifp_state_e;
endpackage

// File: rtl/ifp_buffer.sv
module ifp_buffer #(
    parameter int AW  = 32,
    parameter int IDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  load_addr,
    input  logic [IDW-1:0] load_id,
    input  logic           rsp_valid,
    input  logic [IDW-1:0] rsp_id,
    output logic [AW-1:0]  tag,
    output logic           tag_vld,
    output logic           pending
);
    logic [IDW-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag     <= '0;
            tag_vld <= 1'b0;
            pending <= 1'b0;
            id_q    <= '0;
        end else if (load) begin
            tag     <= load_addr;
            tag_vld <= 1'b1;
            pending <= 1'b1;
            id_q    <= load_id;
        end else if (rsp_valid && pending && (rsp_id == id_q)) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ifp_select.sv
module ifp_select #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] tag0,
    input  logic          vld0,
    input  logic [AW-1:0] tag1,
    input  logic          vld1,
    input  logic [AW-1:0] pc_aln,
    output logic          sel
);
    logic hit0, hit1;

    always_comb begin
        hit0 = vld0 && (tag0 == pc_aln);
        hit1 = vld1 && (tag1 == pc_aln);
        // buffer 0 wins a match; a miss falls back to buffer 1
        if (hit0)      sel = 1'b0;
        else if (hit1) sel = 1'b1;
        else           sel = 1'b1;
    end
endmodule

// File: rtl/ifp_prefetch.sv
module ifp_prefetch
    import ifp_pkg::*;
#(
    parameter int AW          = 32,
    parameter int IDW         = 32,
    parameter int FETCH_BYTES = 16,
    parameter int PW          = 4,
    parameter int WW          = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_pc,
    input  logic           fetch_first,
    input  logic           cache_en,
    input  logic           count_en,
    input  logic           pen_set,
    input  logic [PW-1:0]  pen_val,
    input  logic           rsp_valid,
    input  logic [IDW-1:0] rsp_id,
    output logic           req_valid,
    output logic           req_buf,
    output logic [AW-1:0]  req_addr,
    output logic [IDW-1:0] req_id,
    output logic           stall,
    output logic           fetch_done,
    output logic           cur_buf,
    output logic [WW-1:0]  wait_cycles
);
    localparam int             NBUF     = 2;
    localparam logic [AW-1:0]  STEP     = AW'(FETCH_BYTES);
    localparam logic [AW-1:0]  LOW_MASK = AW'(FETCH_BYTES - 1);
    localparam logic [IDW-1:0] ID_START = {1'b1, {(IDW-1){1'b0}}};

    ifp_state_e st, st_nx;

    logic [AW-1:0]  pc_q, fetch_aln, nxt_addr;
    logic           cur_q, nxt_idx, sel_idx, first_q;
    logic [PW-1:0]  pen_q, pen_cnt;
    logic [IDW-1:0] ctr_q;
    logic [WW-1:0]  wait_q;
    logic           cur_miss, nxt_miss, active, pen_due;

    logic [AW-1:0]  tag     [NBUF];
    logic           tag_vld [NBUF];
    logic           pend    [NBUF];
    logic           load    [NBUF];

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            assign load[g] = req_valid && (req_buf == 1'(g));
            ifp_buffer #(.AW(AW), .IDW(IDW)) u_buf (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load[g]),
                .load_addr (req_addr),
                .load_id   (ctr_q),
                .rsp_valid (rsp_valid),
                .rsp_id    (rsp_id),
                .tag       (tag[g]),
                .tag_vld   (tag_vld[g]),
                .pending   (pend[g])
            );
        end
    endgenerate

    assign fetch_aln = fetch_pc & ~LOW_MASK;

    ifp_select #(.AW(AW)) u_sel (
        .tag0   (tag[0]),
        .vld0   (tag_vld[0]),
        .tag1   (tag[1]),
        .vld1   (tag_vld[1]),
        .pc_aln (fetch_aln),
        .sel    (sel_idx)
    );

    always_comb begin
        active   = cache_en || count_en;
        nxt_idx  = ~cur_q;
        nxt_addr = pc_q + STEP;
        cur_miss = !(tag_vld[cur_q] && (tag[cur_q] == pc_q));
        nxt_miss = !(tag_vld[nxt_idx] && (tag[nxt_idx] == nxt_addr));
        pen_due  = first_q && (pen_q != '0);
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (fetch_valid) st_nx = active ? ST_REQ_CUR : ST_DONE;
            ST_REQ_CUR: st_nx = ST_REQ_NXT;
            ST_REQ_NXT: begin
                if (!count_en)    st_nx = ST_DONE;
                else if (pen_due) st_nx = ST_PENALTY;
                else              st_nx = ST_WAIT;
            end
            ST_PENALTY: if (pen_cnt == PW'(1)) st_nx = ST_WAIT;
            ST_WAIT:    if (!pend[cur_q]) st_nx = ST_DONE;
            ST_DONE:    st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        req_buf   = cur_q;
        req_addr  = pc_q;
        unique case (st)
            ST_REQ_CUR: req_valid = cur_miss;
            ST_REQ_NXT: begin
                req_valid = nxt_miss;
                req_buf   = nxt_idx;
                req_addr  = nxt_addr;
            end
            default: ;
        endcase
        req_id      = ctr_q;
        stall       = (st == ST_REQ_CUR) || (st == ST_REQ_NXT) ||
                      (st == ST_PENALTY) || (st == ST_WAIT);
        fetch_done  = (st == ST_DONE);
        cur_buf     = cur_q;
        wait_cycles = wait_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            cur_q   <= 1'b1;
            first_q <= 1'b0;
            pen_q   <= '0;
            pen_cnt <= '0;
            ctr_q   <= ID_START;
            wait_q  <= '0;
        end else begin
            if (st == ST_IDLE && fetch_valid) begin
                pc_q    <= fetch_aln;
                cur_q   <= sel_idx;
                first_q <= fetch_first;
                wait_q  <= '0;
            end
            if (req_valid) ctr_q <= ctr_q + IDW'(1);
            if (st == ST_REQ_NXT && count_en && pen_due) begin
                pen_cnt <= pen_q;
                pen_q   <= '0;
            end
            if (st == ST_PENALTY) pen_cnt <= pen_cnt - PW'(1);
            if (st == ST_WAIT && pend[cur_q] && wait_q != '1)
                wait_q <= wait_q + WW'(1);
            if (pen_set) pen_q <= pen_val;
        end
    end
endmodule

// File: rtl/ifp_prefetch_chk.sv
module ifp_prefetch_chk #(
    parameter int AW          = 32,
    parameter int IDW         = 32,
    parameter int FETCH_BYTES = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_buf,
    input logic [AW-1:0]  req_addr,
    input logic [IDW-1:0] req_id,
    input logic           stall,
    input logic           fetch_done
);
    localparam int             OFS      = $clog2(FETCH_BYTES);
    localparam logic [IDW-1:0] ID_START = {1'b1, {(IDW-1){1'b0}}};

    logic           seen_q;
    logic [IDW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (req_valid) begin
            seen_q <= 1'b1;
            last_q <= req_id;
        end
    end

    AST_FIRST_ID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !seen_q |-> req_id == ID_START); // R1
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[OFS-1:0] == '0); // R2
    AST_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |->
            (req_addr == $past(req_addr) + AW'(FETCH_BYTES)) && (req_buf != $past(req_buf))); // R5
    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && seen_q |-> req_id == last_q + IDW'(1)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done); // R8
    AST_DONE_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> !stall); // R8
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> !req_valid); // R10
endmodule

bind ifp_prefetch ifp_prefetch_chk #(
    .AW(AW), .IDW(IDW), .FETCH_BYTES(FETCH_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_buf    (req_buf),
    .req_addr   (req_addr),
    .req_id     (req_id),
    .stall      (stall),
    .fetch_done (fetch_done)
);

// File: tb/ifp_prefetch_bench.sv
`timescale 1ns/1ps
module ifp_prefetch_bench;
    localparam int AW = 32, IDW = 32, FB = 16, PW = 4, WW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           fetch_valid, fetch_first, cache_en, count_en, pen_set, rsp_valid;
    logic [AW-1:0]  fetch_pc;
    logic [PW-1:0]  pen_val;
    logic [IDW-1:0] rsp_id;
    logic           req_valid, req_buf, stall, fetch_done, cur_buf;
    logic [AW-1:0]  req_addr;
    logic [IDW-1:0] req_id;
    logic [WW-1:0]  wait_cycles;

    always #10 clk = ~clk; // 50 MHz

    ifp_prefetch #(.AW(AW), .IDW(IDW), .FETCH_BYTES(FB), .PW(PW), .WW(WW)) u_ifp_prefetch (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_first(fetch_first), .cache_en(cache_en), .count_en(count_en),
        .pen_set(pen_set), .pen_val(pen_val), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .req_valid(req_valid), .req_buf(req_buf), .req_addr(req_addr), .req_id(req_id),
        .stall(stall), .fetch_done(fetch_done), .cur_buf(cur_buf), .wait_cycles(wait_cycles)
    );

    int tests = 0, fails = 0;
    logic [IDW-1:0] exp_id = 32'h8000_0000;

    // fetch log
    int             log_n, done_k;
    logic [AW-1:0]  log_addr [4];
    logic           log_buf  [4];
    logic [IDW-1:0] log_id   [4];
    logic [WW-1:0]  got_wait;
    logic           got_cur;
    logic           auto_rsp = 1'b1;
    int             man_k0 = 0, man_k1 = 0;
    logic [IDW-1:0] man_id0 = '0, man_id1 = '0;

    typedef struct packed {
        logic [31:0] pc;
        logic        cur;
        logic [1:0]  nreq;
        logic        fbuf;
        logic [31:0] faddr;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h100, 1'b1, 2'd2, 1'b1, 32'h100},  // cold miss
        '{32'h108, 1'b1, 2'd0, 1'b0, 32'h0},    // hit buffer 1
        '{32'h114, 1'b0, 2'd1, 1'b1, 32'h120},  // hit buffer 0, refill next
        '{32'h128, 1'b1, 2'd1, 1'b0, 32'h130},  // sequential step
        '{32'h500, 1'b1, 2'd2, 1'b1, 32'h500},  // far jump
        '{32'h510, 1'b0, 2'd1, 1'b1, 32'h520},  // hit buffer 0
        '{32'h50C, 1'b1, 2'd1, 1'b1, 32'h500}   // miss, next line present
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] pc, input logic first);
        logic           prev_v;
        logic [IDW-1:0] prev_id;
        log_n = 0; done_k = 0; prev_v = 1'b0; prev_id = '0;
        fetch_valid = 1'b1; fetch_pc = pc; fetch_first = first;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            rsp_valid = 1'b0;
            if (auto_rsp && prev_v) begin rsp_valid = 1'b1; rsp_id = prev_id; end
            if (k == man_k0) begin rsp_valid = 1'b1; rsp_id = man_id0; end
            if (k == man_k1) begin rsp_valid = 1'b1; rsp_id = man_id1; end
            prev_v = req_valid; prev_id = req_id;
            if (req_valid && log_n < 4) begin
                log_addr[log_n] = req_addr; log_buf[log_n] = req_buf;
                log_id[log_n] = req_id; log_n++;
            end
            if (fetch_done) begin
                done_k = k; got_wait = wait_cycles; got_cur = cur_buf;
                break;
            end
            @(negedge clk);
        end
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic check_ids();
        for (int i = 0; i < log_n; i++) begin
            chk(log_id[i] == exp_id, "R6", log_id[i], exp_id);
            exp_id = exp_id + 1;
        end
    endtask

    task automatic arm_penalty(input logic [PW-1:0] v);
        pen_set = 1'b1; pen_val = v;
        @(posedge clk); @(negedge clk);
        pen_set = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [IDW-1:0] nid;
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0; fetch_first = 1'b0;
        cache_en = 1'b1; count_en = 1'b1; pen_set = 1'b0; pen_val = '0;
        rsp_valid = 1'b0; rsp_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_valid && !fetch_done && !stall, "R1", {29'd0, req_valid, fetch_done, stall}, 32'd0);
        chk(wait_cycles == '0, "R1", 32'(wait_cycles), 32'd0);

        // table walk: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < 7; v++) begin
            if (v == 0) begin
                do_fetch(VECS[v].pc, 1'b0);
                chk(log_n > 0 && log_id[0] == 32'h8000_0000, "R1", log_id[0], 32'h8000_0000);
            end else begin
                do_fetch(VECS[v].pc, 1'b0);
            end
            chk(got_cur == VECS[v].cur, (VECS[v].nreq == 2) ? "R4" : "R3", 32'(got_cur), 32'(VECS[v].cur));
            chk(log_n == int'(VECS[v].nreq), "R5", log_n, 32'(VECS[v].nreq));
            if (log_n > 0 && VECS[v].nreq > 0) begin
                chk(log_addr[0] == VECS[v].faddr, "R2", log_addr[0], VECS[v].faddr);
                chk(log_buf[0] == VECS[v].fbuf, "R4", 32'(log_buf[0]), 32'(VECS[v].fbuf));
            end
            if (log_n == 2) begin
                chk(log_addr[1] == VECS[v].faddr + FB, "R5", log_addr[1], VECS[v].faddr + FB);
                chk(log_buf[1] != log_buf[0], "R5", 32'(log_buf[1]), 32'(!log_buf[0]));
            end
            chk(done_k == 4, "R8", done_k, 4);
            check_ids();
        end

        // R7 / R8: prefetch answered first, current answered late
        auto_rsp = 1'b0;
        nid = exp_id;
        man_k0 = 4; man_id0 = nid + 1;
        man_k1 = 7; man_id1 = nid;
        do_fetch(32'h904, 1'b0);
        chk(log_n == 2 && log_addr[0] == 32'h900, "R2", log_addr[0], 32'h900);
        chk(done_k == 9, "R7", done_k, 9);
        chk(got_wait == 8'd5, "R8", 32'(got_wait), 32'd5);
        check_ids();
        auto_rsp = 1'b1; man_k0 = 0; man_k1 = 0;

        // R9: penalty only at packet start, paid once
        arm_penalty(4'd3);
        do_fetch(32'h908, 1'b0);
        chk(done_k == 4 && log_n == 0, "R9", done_k, 4);
        do_fetch(32'h908, 1'b1);
        chk(done_k == 7, "R9", done_k, 7);
        do_fetch(32'h908, 1'b1);
        chk(done_k == 4, "R9", done_k, 4);

        // R11: accounting off, cache on
        count_en = 1'b0;
        arm_penalty(4'd2);
        do_fetch(32'hA00, 1'b1);
        chk(log_n == 2, "R11", log_n, 2);
        chk(done_k == 3, "R11", done_k, 3);
        check_ids();

        // R10: fully suppressed
        cache_en = 1'b0;
        do_fetch(32'hC00, 1'b1);
        chk(log_n == 0, "R10", log_n, 0);
        chk(done_k == 1, "R10", done_k, 1);

        // penalty survived the suppressed fetches
        cache_en = 1'b1; count_en = 1'b1;
        do_fetch(32'hC00, 1'b0);
        chk(done_k == 4 && log_n == 2, "R9", done_k, 4);
        check_ids();
        do_fetch(32'hC00, 1'b1);
        chk(done_k == 6, "R11", done_k, 6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule